// File: doc/BRIEF.md
# Alarm RAM with Wildcard Digit Comparator

This block keeps a small alarm store, laid out digit for digit like the live time-of-day counter, and tells the rest of the chip whenever the counter agrees with it. Software reaches the store over a byte-wide bus. Each byte address carries two BCD digit positions: the lower-order digit sits in bits 3:0 and the higher-order digit in bits 7:4. The store occupies addresses 0x08 to 0x0F. Address 0x08 holds the milliseconds pair, and each following address holds the next pair up the time scale, ending with the month pair at 0x0F.

Every cycle, each stored digit is compared with its matching counter digit. A stored digit with both of its top bits set works as a don't-care. A counter bit that is not needed to encode its field is compared as zero. Two positions never take part in the compare: the milliseconds units digit and the day-of-week tens digit. Those two positions have no storage, so the store holds 14 four-bit digits (56 bits). The combined result is registered once and driven out on `match_o`, where the interrupt logic picks it up.

The counter arrives as `cnt_i`, 16 digits. Digit k sits on bits 4k+3:4k. The positions run 0 ms units, 1 ms tens, 2 hundredths, 3 tenths, 4/5 seconds units/tens, 6/7 minutes, 8/9 hours, 10/11 day-of-week units/tens, 12/13 day-of-month, 14/15 month.

Top module: `alarm_cmp_ram`

## Requirements
- R1: While `rst_ni` is low, `match_o` is 0 and every stored digit clears to 0, so every read in 0x08..0x0F returns 0x00 after reset.
- R2: A write to an address in 0x08..0x0F stores all four bits of both digits. A later read of that address returns them, with the lower-order digit in bits 3:0.
- R3: Bits 3:0 of address 0x08 (ms units) and bits 7:4 of address 0x0D (day-of-week tens) always read 0 and ignore writes. The counter digits at positions 0 and 11 never affect `match_o`.
- R4: A write to an address outside 0x08..0x0F changes no stored digit, and a read of such an address returns 0x00.
- R5: A stored digit whose bits 3:2 are both 1 (for example 0xC) matches any counter value at its position.
- R6: The following counter bits are unused: bit 3 of positions 5, 7 and 10; bits 3:2 of positions 9 and 13; bits 3:1 of position 15. Each of them is compared as 0. Setting one of them does not change the result, and a stored non-wildcard digit with a 1 in such a bit never matches.
- R7: `match_o` is 1 only when every compared position matches. A single mismatching position forces it to 0.
- R8: `match_o` reflects `cnt_i` and the stored digits as they were at the previous rising clock edge. A write at edge N is first visible in `match_o` after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for `addr_i`/`wdata_i` |
| addr_i | input | 5 | Byte address; the store decodes 0x08..0x0F |
| wdata_i | input | 8 | Write data, two digits |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| cnt_i | input | 64 | Live counter, 16 BCD digit positions |
| match_o | output | 1 | Registered all-digits-match flag |

## Verification
The assertions assume that `cnt_i` is driven from registers in the same clock domain, so it is stable around the rising edge. They also assume that `wr_i` is never left unknown once reset is released. The write/read property further assumes that a read-back keeps the address that was just written. The stimulus changes the counter and the bus only on the falling edge and holds `wr_i` low through reset. It always reads the last-written address in the cycle after the write.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int unsigned DIGITS = 16;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDRS  = DIGITS / 2;
  localparam int unsigned CNT_W  = DIGITS * NIB_W;

  // positions with no storage and no compare
  function automatic logic excluded(input int unsigned pos);
    return (pos == 0) || (pos == 11);
  endfunction

  // counter bits that carry information at each position
  function automatic logic [NIB_W-1:0] used_mask(input int unsigned pos);
    case (pos)
      5, 7, 10: used_mask = 4'h7;
      9, 13:    used_mask = 4'h3;
      15:       used_mask = 4'h1;
      default:  used_mask = 4'hF;
    endcase
  endfunction
endpackage

// File: rtl/alarm_digit_store.sv
module alarm_digit_store
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned BASE_ADDR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  ram_o
);
  localparam int unsigned IDX_W = $clog2(ADDRS);

  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [BYTE_W-1:0] keep;

  assign off = addr_i - ADDR_W'(BASE_ADDR);
  assign hit = (addr_i >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(ADDRS));
  assign idx = off[IDX_W-1:0];

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    if (excluded(k)) begin : g_none
      assign ram_o[k*NIB_W +: NIB_W] = '0;
    end else begin : g_reg
      logic [NIB_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (wr_i && hit && idx == IDX_W'(k / 2)) q <= wdata_i[(k % 2)*NIB_W +: NIB_W];
      end
      assign ram_o[k*NIB_W +: NIB_W] = q;
    end
  end

  assign rdata_o = hit ? ram_o[{idx, 3'b000} +: BYTE_W] : '0;

  // nibbles that hold storage at the current address
  always_comb begin
    keep = 8'hFF;
    if (addr_i == ADDR_W'(BASE_ADDR))     keep = 8'hF0;
    if (addr_i == ADDR_W'(BASE_ADDR + 5)) keep = 8'h0F;
  end

  // R2
  wr_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit) ##1 (addr_i == $past(addr_i)) |-> rdata_o == ($past(wdata_i) & keep));
  // R3
  excl_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(BASE_ADDR)) |-> rdata_o[3:0] == 4'h0);
  // R3
  excl_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(BASE_ADDR + 5)) |-> rdata_o[7:4] == 4'h0);
  // R4
  oob_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hit) |=> $stable(ram_o));
endmodule

// File: rtl/alarm_digit_cmp.sv
module alarm_digit_cmp
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned POS = 1
) (
  input  logic [NIB_W-1:0] ram_dig_i,
  input  logic [NIB_W-1:0] cnt_dig_i,
  output logic             hit_o
);
  if (excluded(POS)) begin : g_skip
    assign hit_o = 1'b1;
  end else begin : g_cmp
    logic wild;
    assign wild  = &ram_dig_i[NIB_W-1:NIB_W-2];
    // unused counter bits forced to zero before the compare
    assign hit_o = wild || (ram_dig_i == (cnt_dig_i & used_mask(POS)));
  end
endmodule

// File: rtl/alarm_cmp_ram.sv
module alarm_cmp_ram
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned BASE_ADDR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [63:0]       cnt_i,
  output logic              match_o
);
  logic [CNT_W-1:0]  ram_w;
  logic [DIGITS-1:0] hit_vec;
  logic [DIGITS-1:0] wild_vec;
  logic              match_q;

  alarm_digit_store #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) store_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .ram_o  (ram_w)
  );

  for (genvar k = 0; k < DIGITS; k++) begin : g_pos
    alarm_digit_cmp #(.POS(k)) cmp_i (
      .ram_dig_i(ram_w[k*NIB_W +: NIB_W]),
      .cnt_dig_i(cnt_i[k*NIB_W +: NIB_W]),
      .hit_o    (hit_vec[k])
    );
    if (excluded(k)) begin : g_wx
      assign wild_vec[k] = 1'b1;
    end else begin : g_wd
      assign wild_vec[k] = ram_w[k*NIB_W + 3] & ram_w[k*NIB_W + 2];
      // R7
      mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wild_vec[k] && ram_w[k*NIB_W +: NIB_W] != (cnt_i[k*NIB_W +: NIB_W] & used_mask(k)))
        |=> !match_o);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= &hit_vec;
  end

  assign match_o = match_q;

  // R5
  all_wild_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&wild_vec) |=> match_o);
  // R8
  match_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && match_o) |-> $past(&wild_vec) || $past(cnt_i[7:4] & 4'hF) == $past(ram_w[7:4]) || $past(ram_w[7] & ram_w[6]));
endmodule

// File: tb/alarm_cmp_ram_tb_top.sv
`timescale 1ns/1ps
module alarm_cmp_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [63:0] cnt = '0;
  logic        match;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [3:0] m [16];

  typedef struct {
    int    due;
    bit    exp;
    string req;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  alarm_cmp_ram dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cnt_i(cnt), .match_o(match)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] umask(input int k);
    case (k)
      5, 7, 10: return 4'h7;
      9, 13:    return 4'h3;
      15:       return 4'h1;
      default:  return 4'hF;
    endcase
  endfunction

  function automatic bit skip(input int k);
    return (k == 0) || (k == 11);
  endfunction

  function automatic bit model_match(input logic [63:0] v);
    for (int k = 0; k < 16; k++) begin
      if (skip(k)) continue;
      if (m[k][3] && m[k][2]) continue;
      if (m[k] != (v[k*4 +: 4] & umask(k))) return 1'b0;
    end
    return 1'b1;
  endfunction

  // monitor: pops scoreboard items once their cycle has come
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      check(match === it.exp, it.req, match, it.exp);
    end
  end

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    if (a >= 5'h08 && a <= 5'h0F) begin
      int p;
      p = (a - 8) * 2;
      if (!skip(p))     m[p]     = d[3:0];
      if (!skip(p + 1)) m[p + 1] = d[7:4];
    end
  endtask

  task automatic rd_chk(input logic [4:0] a, input string req);
    logic [7:0] exp;
    @(negedge clk);
    addr = a;
    #1;
    exp = (a >= 5'h08 && a <= 5'h0F) ? {m[(a-8)*2+1], m[(a-8)*2]} : 8'h00;
    check(rdata === exp, req, rdata, exp);
  endtask

  task automatic load_ram(input logic [63:0] v);
    for (int a = 0; a < 8; a++) bus_wr(5'(a + 8), v[a*8 +: 8]);
  endtask

  // driver: sets the counter and pushes the expected flag for the next cycle
  task automatic step(input logic [63:0] v, input string req);
    item_t it;
    @(negedge clk);
    cnt = v;
    it.due = cyc + 1; it.exp = model_match(v); it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  localparam logic [63:0] T = 64'h0628_0310_1542_7350;

  initial begin
    for (int k = 0; k < 16; k++) m[k] = 4'h0;
    repeat (4) @(negedge clk);
    check(match === 1'b0, "R1 match in reset", match, 0);
    rst_n = 1'b1;
    for (int a = 8; a < 16; a++) rd_chk(5'(a), "R1 cleared store");

    // R2 / R3 write and read back
    for (int a = 8; a < 16; a++) bus_wr(5'(a), 8'hA5 + 8'(a * 8'h11));
    for (int a = 8; a < 16; a++) rd_chk(5'(a), "R2 read back");
    bus_wr(5'h08, 8'hFF); rd_chk(5'h08, "R3 ms units reads zero");
    bus_wr(5'h0D, 8'hFF); rd_chk(5'h0D, "R3 dow tens reads zero");

    // R4 out-of-range addresses
    bus_wr(5'h00, 8'h3C); bus_wr(5'h10, 8'h5A); bus_wr(5'h1F, 8'hFF);
    rd_chk(5'h00, "R4 low oob read");
    rd_chk(5'h10, "R4 high oob read");
    for (int a = 8; a < 16; a++) rd_chk(5'(a), "R4 store untouched");

    // R5 all wildcards
    load_ram(64'hCCCC_CCCC_CCCC_CCCC);
    step(T, "R5 wild T"); step(~T, "R5 wild inv"); step('0, "R5 wild zero");
    step('1, "R5 wild ones"); drain();

    // R7 / R8 exact match and single mismatch
    load_ram(T);
    step(T, "R8 exact match");
    step(T ^ 64'h0000_0000_0001_0000, "R7 sec units differ");
    step(T, "R8 back to match");
    step(T ^ 64'h1000_0000_0000_0000, "R7 month tens differ");
    step(T ^ 64'h0000_0000_0000_0005, "R3 ms units ignored");
    step(T ^ 64'h0000_9000_0000_0000, "R3 dow tens ignored");
    drain();
    bus_wr(5'h08, 8'h57);
    step(T ^ 64'h0000_0000_0000_0009, "R3 write to ms units ignored"); drain();

    // R6 unused counter bits
    step(T | 64'h0000_0080_0000_0000, "R6 hr tens bit3 set");
    step(T | 64'h2000_0000_0000_0000, "R6 month tens bit1 set");
    step(T | 64'h0000_0000_8000_0000, "R6 min tens bit3 set");
    drain();
    bus_wr(5'h0C, 8'h40);
    step(T, "R6 ram unused bit set");
    step(T | 64'h0000_0040_0000_0000, "R6 ram and cnt unused bit");
    drain();
    bus_wr(5'h0C, 8'hC0);
    step(T, "R5 hr tens wildcard");
    step(T ^ 64'h0000_0020_0000_0000, "R5 hr tens wildcard any"); drain();

    // R7 daily alarm at 10:15
    load_ram(64'hCCCC_0C10_1500_0000);
    step(64'h0312_0410_1500_0000, "R7 alarm hit");
    step(64'h0312_0410_1501_0000, "R7 alarm one second late");
    step(64'h1129_0610_1500_0000, "R7 alarm other day");
    step(64'h0312_0411_1500_0000, "R7 alarm wrong hour");
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule